// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a high-precision event timer. A free-running main counter arrives from outside. The channel holds a comparator value. It raises a sticky status flag when the counter equals the comparator. The status flag drives a level interrupt output, which is gated by an enable bit. Software reaches the channel through a small register port. One write strobe and a 2-bit select address the configuration word, the two halves of the comparator and the low half of the stored period. A separate read select returns the addressed word combinationally.

One parameter builds either a full channel or a reduced channel. The full channel is 64 bits wide, supports periodic mode and can be forced to 32-bit operation. The reduced channel is 32 bits wide, one-shot only, and ignores writes to the features it lacks. In periodic mode each match adds the stored period to the comparator. A self-clearing arm bit lets software load the comparator itself, instead of the period, with the next comparator write. Forcing 32-bit mode clears the upper comparator and period halves, and they stay clear.

Top module: `evt_timer_chan`

## Requirements
- R1: The interrupt route field (configuration bits 10:6) resets to 20. A written value is stored only if the channel supports it: 20 to 23 on the full channel, and 11 or 20 to 23 on the reduced channel. Any other value leaves the previous route in place, so the read-back differs from what was written.
- R2: Configuration bit 2 (periodic capable) and bit 3 (64-bit size) both read 1 on the full channel and 0 on the reduced channel. Writes to them have no effect.
- R3: On the reduced channel, the type bit (bit 1) and the 32-bit mode bit (bit 5) always read 0. The upper comparator half (select 2) reads 0, and writes to it are ignored.
- R4: Configuration bit 0 enables the channel. The interrupt output equals the status flag ANDed with this bit. A match that occurs while the channel is disabled still sets the status flag.
- R5: A match seen at a clock edge sets the status flag at that edge. The flag holds until an edge where the clear input is high and no match occurs. A match wins over a clear in the same cycle.
- R6: In 32-bit mode only the low 32 counter bits are compared. Setting bit 5 from 0 to 1 zeroes the upper halves of the comparator and the period. Writes to select 2 are ignored while bit 5 is 1. The upper halves remain zero after bit 5 returns to 0, until they are written again.
- R7: The arm bit (bit 4) always reads 0. Writing it as 1 together with type 1 arms the channel. A configuration write with type 0 disarms it. While armed, the next comparator half write loads the comparator and disarms the channel.
- R8: When type is 1 and the channel is not armed, comparator writes to select 1 or 2 go to the period instead. Each match adds the period to the comparator: the addition is 64-bit wide, or wraps modulo 2^32 with the upper half zero in 32-bit mode.
- R9: When type is 0, comparator writes load the comparator, and a match leaves the comparator unchanged.
- R10: Selects 0, 1, 2 and 3 address the configuration, the low comparator, the high comparator and the low period. Select 3 is read-only. Reset clears the configuration bits, the status flag and the period. Reset loads the comparator with all ones: 64 bits on the full channel, the low 32 bits on the reduced channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_cnt | input | CNT_W | Free-running main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | CNT_W/2 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | CNT_W/2 | Combinational read data |
| sts_clr | input | 1 | Write-one-to-clear for the status flag |
| irq | output | 1 | Level interrupt (status AND enable) |

## Verification
The bench runs two channels side by side, one full and one reduced, on identical stimulus. Each clock, both are compared against a behavioural model.

Four counter patterns are used:
- A counter that rises through a low 64-bit comparator value, which separates one-shot matching from reloading.
- A counter whose upper word is non-zero while its low word matches. This tells 64-bit compares apart from 32-bit compares, and the full channel apart from the reduced one.
- A running counter in periodic mode with clear pulses interleaved. This shows whether writes land in the period or the comparator, and when arming takes effect.
- A counter crossing the 2^32 boundary in forced 32-bit periodic mode. This exposes period sums that fail to wrap.

The read select rotates every cycle, so writes that are ignored or rejected are seen at the read port.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // register select encoding
    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_CMP_LO = 2'd1,
        SEL_CMP_HI = 2'd2,
        SEL_PER_LO = 2'd3
    } regsel_e;

    // configuration word bit positions
    localparam int EN_BIT    = 0;
    localparam int TYPE_BIT  = 1;
    localparam int PCAP_BIT  = 2;
    localparam int SCAP_BIT  = 3;
    localparam int VSET_BIT  = 4;
    localparam int M32_BIT   = 5;
    localparam int ROUTE_LSB = 6;
    localparam int ROUTE_W   = 5;

    localparam logic [ROUTE_W-1:0] ROUTE_RST = 5'd20;

    // configuration fields carried by a write
    typedef struct packed {
        logic               en;
        logic               per;
        logic               vset;
        logic               m32;
        logic [ROUTE_W-1:0] route;
    } cfg_wr_s;

    // configuration state
    typedef struct packed {
        logic               en;
        logic               per;
        logic               m32;
        logic               armed;
        logic [ROUTE_W-1:0] route;
    } cfg_s;

    function automatic logic route_ok(input logic [ROUTE_W-1:0] v, input logic full);
        return ((v >= 5'd20) && (v <= 5'd23)) || (!full && (v == 5'd11));
    endfunction

endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
    import evt_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cfg_wr,
    input  cfg_wr_s wr_fields,
    input  logic    cmp_used,
    output cfg_s    cfg_q,
    output logic    enter32
);

    cfg_s cfg_d;

    always_comb begin
        cfg_d   = cfg_q;
        enter32 = 1'b0;
        if (cfg_wr) begin
            cfg_d.en  = wr_fields.en;
            cfg_d.per = FULL & wr_fields.per;
            cfg_d.m32 = FULL & wr_fields.m32;
            enter32   = cfg_d.m32 & ~cfg_q.m32;
            if (route_ok(wr_fields.route, FULL)) begin
                cfg_d.route = wr_fields.route;
            end
            if (!cfg_d.per) begin
                cfg_d.armed = 1'b0;
            end else if (wr_fields.vset) begin
                cfg_d.armed = 1'b1;
            end
        end else if (cmp_used) begin
            cfg_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en    <= 1'b0;
            cfg_q.per   <= 1'b0;
            cfg_q.m32   <= 1'b0;
            cfg_q.armed <= 1'b0;
            cfg_q.route <= ROUTE_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assert_route_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        route_ok(cfg_q.route, FULL));

    assert_armed_only_periodic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.armed |-> cfg_q.per);

    assert_disarm_after_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_used && !cfg_wr) |=> !cfg_q.armed);

endmodule

// File: rtl/evt_cmp_unit.sv
module evt_cmp_unit #(
    parameter bit FULL  = 1'b1,
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   main_cnt,
    input  logic               per,
    input  logic               m32,
    input  logic               armed,
    input  logic               enter32,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [CNT_W-1:0]   cmp_q,
    output logic [CNT_W/2-1:0] period_lo,
    output logic               match,
    output logic               cmp_used
);

    localparam int HW = CNT_W / 2;
    localparam logic [CNT_W-1:0] RST_CMP = FULL ? {CNT_W{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] period;
    } cmp_state_s;

    cmp_state_s st_d, st_q;
    logic       wide;
    logic       load_cmp;

    assign wide      = FULL && !m32;
    assign load_cmp  = !per || armed;
    assign cmp_used  = (wr_lo || wr_hi) && per && armed;
    assign cmp_q     = st_q.cmp;
    assign period_lo = st_q.period[HW-1:0];

    always_comb begin
        if (wide) begin
            match = (main_cnt == st_q.cmp);
        end else begin
            match = (main_cnt[HW-1:0] == st_q.cmp[HW-1:0]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            if (load_cmp) st_d.cmp[HW-1:0]    = wr_data;
            else          st_d.period[HW-1:0] = wr_data;
        end else if (wr_hi) begin
            if (load_cmp) st_d.cmp[CNT_W-1:HW]    = wr_data;
            else          st_d.period[CNT_W-1:HW] = wr_data;
        end else if (match && per) begin
            if (wide) begin
                st_d.cmp = st_q.cmp + st_q.period;
            end else begin
                st_d.cmp = {{HW{1'b0}}, st_q.cmp[HW-1:0] + st_q.period[HW-1:0]};
            end
        end
        if (enter32 || !FULL) begin
            st_d.cmp[CNT_W-1:HW]    = '0;
            st_d.period[CNT_W-1:HW] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp    <= RST_CMP;
            st_q.period <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_upper_zero_in_32_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m32 |-> (st_q.cmp[CNT_W-1:HW] == '0));

    assert_periodic_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (per && match && !wr_lo && !wr_hi && !enter32)
        |=> (st_q.cmp[HW-1:0] == $past(st_q.cmp[HW-1:0] + st_q.period[HW-1:0])));

    assert_oneshot_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!per && !wr_lo && !wr_hi && !enter32) |=> $stable(st_q.cmp));

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr,
    input  logic en,
    output logic irq
);

    logic sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (clr)   sts_d = 1'b0;
        if (match) sts_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= 1'b0;
        else        sts_q <= sts_d;
    end

    assign irq = sts_q & en;

    assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> sts_q);

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !clr) |=> sts_q);

    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_pkg::*;
#(
    parameter bit FULL  = 1'b1,
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   main_cnt,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic [1:0]         rd_sel,
    output logic [CNT_W/2-1:0] rd_data,
    input  logic               sts_clr,
    output logic               irq
);

    localparam int HW = CNT_W / 2;

    regsel_e          wsel, rsel;
    cfg_wr_s          wr_fields;
    cfg_s             cfg;
    logic             cfg_wr, wr_lo, wr_hi;
    logic             enter32, cmp_used, match;
    logic [CNT_W-1:0] cmp_val;
    logic [HW-1:0]    period_lo;

    assign wsel = regsel_e'(wr_sel);
    assign rsel = regsel_e'(rd_sel);

    assign cfg_wr = wr_en && (wsel == SEL_CFG);
    assign wr_lo  = wr_en && (wsel == SEL_CMP_LO);
    assign wr_hi  = wr_en && (wsel == SEL_CMP_HI) && FULL && !cfg.m32;

    assign wr_fields.en    = wr_data[EN_BIT];
    assign wr_fields.per   = wr_data[TYPE_BIT];
    assign wr_fields.vset  = wr_data[VSET_BIT];
    assign wr_fields.m32   = wr_data[M32_BIT];
    assign wr_fields.route = wr_data[ROUTE_LSB +: ROUTE_W];

    evt_cfg_reg #(.FULL(FULL)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .wr_fields (wr_fields),
        .cmp_used  (cmp_used),
        .cfg_q     (cfg),
        .enter32   (enter32)
    );

    evt_cmp_unit #(.FULL(FULL), .CNT_W(CNT_W)) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_cnt  (main_cnt),
        .per       (cfg.per),
        .m32       (cfg.m32),
        .armed     (cfg.armed),
        .enter32   (enter32),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .cmp_q     (cmp_val),
        .period_lo (period_lo),
        .match     (match),
        .cmp_used  (cmp_used)
    );

    evt_irq_status sts_i (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .clr   (sts_clr),
        .en    (cfg.en),
        .irq   (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_CFG: begin
                rd_data[EN_BIT]                = cfg.en;
                rd_data[TYPE_BIT]              = cfg.per;
                rd_data[PCAP_BIT]              = FULL;
                rd_data[SCAP_BIT]              = FULL;
                rd_data[M32_BIT]               = cfg.m32;
                rd_data[ROUTE_LSB +: ROUTE_W]  = cfg.route;
            end
            SEL_CMP_LO: rd_data = cmp_val[HW-1:0];
            SEL_CMP_HI: rd_data = cmp_val[CNT_W-1:HW];
            SEL_PER_LO: rd_data = period_lo;
            default:    rd_data = '0;
        endcase
    end

    assert_vset_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_CFG) |-> !rd_data[VSET_BIT]);

    assert_hi_write_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wsel == SEL_CMP_HI) && cfg.m32) |=> (cmp_val[CNT_W-1:HW] == '0));

endmodule

// File: tb/evt_timer_chan_tb.sv
`timescale 1ns/1ps
module evt_timer_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] main_cnt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic        sts_clr = 1'b0;
    logic        irq_f, irq_r;
    logic [31:0] rd_f, rd_r;

    always #2.5 clk = ~clk;

    evt_timer_chan #(.FULL(1'b1), .CNT_W(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_f), .sts_clr(sts_clr), .irq(irq_f));

    evt_timer_chan #(.FULL(1'b0), .CNT_W(64)) dut_r (
        .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_r), .sts_clr(sts_clr), .irq(irq_r));

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    cnt_run = 0;
    string cur_req = "R10";

    // behavioural model, index 0 = reduced channel, 1 = full channel
    logic [63:0] m_cmp [2];
    logic [63:0] m_per [2];
    bit          m_en [2], m_type [2], m_m32 [2], m_arm [2], m_sts [2];
    logic [4:0]  m_route [2];

    function automatic bit legal_route(logic [4:0] v, bit full);
        return (v >= 20 && v <= 23) || (!full && v == 11);
    endfunction

    task automatic model_reset();
        for (int f = 0; f < 2; f++) begin
            m_cmp[f]   = (f == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
            m_per[f]   = '0;
            m_en[f]    = 0; m_type[f] = 0; m_m32[f] = 0; m_arm[f] = 0; m_sts[f] = 0;
            m_route[f] = 5'd20;
        end
    endtask

    task automatic model_step(int f);
        bit full = (f == 1);
        bit wide = full && !m_m32[f];
        bit hit  = wide ? (main_cnt == m_cmp[f]) : (main_cnt[31:0] == m_cmp[f][31:0]);
        logic [63:0] ncmp = m_cmp[f];
        logic [63:0] nper = m_per[f];
        bit nen = m_en[f], ntype = m_type[f], nm32 = m_m32[f], narm = m_arm[f];
        logic [4:0] nroute = m_route[f];
        bit to32 = 0;
        bit lo = wr_en && wr_sel == 2'd1;
        bit hi = wr_en && wr_sel == 2'd2 && wide;
        if (wr_en && wr_sel == 2'd0) begin
            nen   = wr_data[0];
            ntype = full && wr_data[1];
            nm32  = full && wr_data[5];
            to32  = nm32 && !m_m32[f];
            if (legal_route(wr_data[10:6], full)) nroute = wr_data[10:6];
            if (!ntype) narm = 0;
            else if (wr_data[4]) narm = 1;
        end
        if (lo || hi) begin
            bit to_cmp = !m_type[f] || m_arm[f];
            if (lo) begin
                if (to_cmp) ncmp[31:0] = wr_data; else nper[31:0] = wr_data;
            end else begin
                if (to_cmp) ncmp[63:32] = wr_data; else nper[63:32] = wr_data;
            end
            if (m_type[f] && m_arm[f] && !(wr_en && wr_sel == 2'd0)) narm = 0;
        end else if (hit && m_type[f]) begin
            if (wide) ncmp = m_cmp[f] + m_per[f];
            else ncmp = {32'h0, m_cmp[f][31:0] + m_per[f][31:0]};
        end
        if (to32 || !full) begin
            ncmp[63:32] = '0;
            nper[63:32] = '0;
        end
        m_sts[f]   = hit || (m_sts[f] && !sts_clr);
        m_cmp[f]   = ncmp; m_per[f] = nper;
        m_en[f]    = nen; m_type[f] = ntype; m_m32[f] = nm32; m_arm[f] = narm;
        m_route[f] = nroute;
    endtask

    function automatic logic [31:0] exp_rd(int f, logic [1:0] s);
        bit full = (f == 1);
        case (s)
            2'd0: return {21'b0, m_route[f], m_m32[f], 1'b0, full, full, m_type[f], m_en[f]};
            2'd1: return m_cmp[f][31:0];
            2'd2: return m_cmp[f][63:32];
            default: return m_per[f][31:0];
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) model_reset();
        else begin
            model_step(0);
            model_step(1);
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("full irq",    {31'b0, irq_f}, {31'b0, m_sts[1] && m_en[1]});
            check("reduced irq", {31'b0, irq_r}, {31'b0, m_sts[0] && m_en[0]});
            check("full rd",     rd_f, exp_rd(1, rd_sel));
            check("reduced rd",  rd_r, exp_rd(0, rd_sel));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        if (cnt_run) main_cnt = main_cnt + 64'd1;
        rd_sel = rd_sel + 2'd1;
    endtask

    task automatic run(int n);
        repeat (n) tick();
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clr();
        sts_clr = 1'b1;
        tick();
        sts_clr = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(bit en, bit typ, bit vset, bit m32, logic [4:0] rt);
        return {21'b0, rt, m32, vset, 2'b00, typ, en};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        run(4);
        rst_n = 1'b1;
        // R10 / R2: reset state and capability bits, seen through rotating reads
        cur_req = "R10"; run(4);
        cur_req = "R2";  wr(2'd0, 32'h0000_000C); run(4);
        // R1: route legality
        cur_req = "R1";
        wr(2'd0, cfgw(0, 0, 0, 0, 5'd5));  run(4);
        wr(2'd0, cfgw(0, 0, 0, 0, 5'd11)); run(4);
        wr(2'd0, cfgw(0, 0, 0, 0, 5'd22)); run(4);
        // R9: one-shot match, no reload
        cur_req = "R9";
        main_cnt = 64'd100; cnt_run = 1;
        wr(2'd0, cfgw(1, 0, 0, 0, 5'd22));
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd130);
        run(40);
        clr(); run(4);
        // R4: disabled channel still records status, irq masked
        cur_req = "R4";
        wr(2'd0, cfgw(0, 0, 0, 0, 5'd22));
        wr(2'd1, main_cnt[31:0] + 32'd6);
        run(12);
        wr(2'd0, cfgw(1, 0, 0, 0, 5'd22)); run(4);
        // R5: clear versus match
        cur_req = "R5";
        clr(); run(3);
        cnt_run = 0;
        wr(2'd1, main_cnt[31:0]);
        sts_clr = 1'b1; run(3); sts_clr = 1'b0;
        wr(2'd1, 32'h0000_0001); clr(); run(3);
        // R3 / R6: upper word differs, low word matches
        cur_req = "R3";
        main_cnt = 64'h0000_0005_0000_0200; cnt_run = 1;
        wr(2'd1, 32'h0000_0210);
        run(24); clr(); run(2);
        wr(2'd2, 32'h0000_0009); run(4);
        cur_req = "R6";
        cnt_run = 0; main_cnt = 64'h0000_0005_0000_0300; cnt_run = 1;
        wr(2'd2, 32'h0000_0005);
        wr(2'd1, 32'h0000_0330);
        wr(2'd0, cfgw(1, 0, 0, 1, 5'd22));
        run(48); clr(); run(2);
        wr(2'd2, 32'h0000_0007); run(4);
        wr(2'd0, cfgw(1, 0, 0, 0, 5'd22)); run(6);
        // R8: periodic with period writes and arming
        cur_req = "R8";
        cnt_run = 0; main_cnt = 64'h0000_0000_0000_1000; cnt_run = 1;
        wr(2'd0, cfgw(1, 1, 0, 0, 5'd22));
        wr(2'd1, 32'd6);
        wr(2'd2, 32'd0);
        cur_req = "R7";
        wr(2'd0, cfgw(1, 1, 1, 0, 5'd22));
        run(3);
        wr(2'd1, main_cnt[31:0] + 32'd10);
        cur_req = "R8";
        for (int k = 0; k < 12; k++) begin
            run(3); clr();
        end
        // R7: arm bit with type 0 has no effect
        cur_req = "R7";
        wr(2'd0, cfgw(1, 0, 1, 0, 5'd22));
        wr(2'd0, cfgw(1, 1, 0, 0, 5'd22));
        wr(2'd1, 32'd9); run(6);
        wr(2'd0, cfgw(1, 1, 1, 0, 5'd22));
        wr(2'd2, 32'd0); run(2);
        wr(2'd1, 32'd4); run(4);
        // R8: 32-bit periodic wrap
        cur_req = "R8";
        cnt_run = 0; main_cnt = 64'h0000_0003_FFFF_FFF0; cnt_run = 1;
        wr(2'd0, cfgw(1, 1, 0, 1, 5'd21));
        wr(2'd1, 32'd8);
        wr(2'd0, cfgw(1, 1, 1, 1, 5'd21));
        wr(2'd1, 32'hFFFF_FFFC);
        for (int k = 0; k < 10; k++) begin
            run(2); clr();
        end
        // R10: period view is read-only
        cur_req = "R10";
        wr(2'd3, 32'h0000_0055); run(8);
        finish_run();
    end

endmodule